// File: doc/BRIEF.md
# Spare-Bit Transmit Stack for CRC-4 Multiframes

This block holds the spare-bit data that goes into the service words of an outgoing E1 CRC-4 multiframe. A host writes up to five bytes through a simple byte port. The block spreads each byte one bit at a time over the eight service words of a multiframe, most significant bit first. The multiframe timing comes from a frame counter (0–15) and a per-frame start strobe. For each frame, the block presents the bit values for service-word bit positions 8 down to 4, plus a flag that says whether those bits are to be inserted.

Writes go into a staging store. At the start of the next multiframe the staging store is copied into a shadow store, and the outputs are always driven from the shadow store. A partial update therefore never splits a multiframe, and if the host writes nothing, the previous five bytes are sent again. At every multiframe start a request flag asks for a refill, and an interrupt pulse can also be enabled. The stack acts only when both the CRC mode enable and the spare-bit enable are set, and no timeslot-0 transparent mode is active.

Top module: `spare_bit_tx_stack`

## Requirements
- R1: After reset, the request flag and interrupt are low and the stored bytes are all 8'hFF, so an odd frame with insertion enabled shows `sa_bits` = 5'h1F.
- R2: When `crc_mode_en` or `spare_en` is low, `sa_valid` is 0, `sa_bits` is 5'h1F and the request flag stays low (it is cleared one cycle after either enable drops).
- R3: When `ts0_transparent` is high, `sa_valid` is 0 and `sa_bits` is 5'h1F.
- R4: In odd frame f with insertion enabled, `sa_valid` is 1 and `sa_bits[4-b]` equals bit (7 - (f>>1)) of stored byte b. Byte 0 (the first written) feeds `sa_bits[4]` (service-word bit position 8), and bytes 1..4 feed bit positions 7..4. Byte bit 7 goes out in frame 1 and bit 0 in frame 15. In even frames, `sa_valid` is 0 and `sa_bits` is 5'h1F.
- R5: Bytes written during a multiframe do not change the outputs until the next multiframe start, which is a cycle with `frame_start`=1 and `frame_idx`=0.
- R6: With no writes, the same five bytes are sent again in every following multiframe.
- R7: At each multiframe start with the stack enabled, `sa_request` goes high on the next cycle. It goes low on the cycle after the fifth byte since that start is written.
- R8: Writes beyond the fifth in one multiframe are ignored.
- R9: Bytes that are not rewritten during a multiframe keep their previous values in the next multiframe.
- R10: `mf_irq` is a one-cycle pulse on the cycle after a multiframe start, raised only when the stack is enabled and both `irq_en` and `mf_irq_mask` are high.
- R11: A write in the same cycle as a multiframe start becomes byte 0 of the new collection. The shadow store loads the bytes collected before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_idx | input | 4 | Current frame number in the multiframe, 0..15 |
| frame_start | input | 1 | One-cycle strobe at the first cycle of each frame |
| crc_mode_en | input | 1 | CRC-4 multiframe mode enable |
| spare_en | input | 1 | Spare-bit stack enable |
| ts0_transparent | input | 1 | Any timeslot-0 transparent mode active; suppresses insertion |
| irq_en | input | 1 | Global interrupt enable |
| mf_irq_mask | input | 1 | Multiframe-begin interrupt enable bit |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| sa_bits | output | 5 | Spare bits for positions 8..4 (bit 4 = position 8) |
| sa_valid | output | 1 | Insert `sa_bits` into this frame's service word |
| sa_request | output | 1 | Refill request flag |
| mf_irq | output | 1 | Multiframe-begin interrupt pulse |

## Verification
Assertions check some properties on every cycle. The shadow store changes only at a multiframe start, and the write pointer never passes five. The request flag falls after a fifth write, and it is low while the stack is disabled. The interrupt appears only right after a multiframe start. The mapping of byte bits to frames and bit positions, the repeat of old data, the drop of extra writes, the keeping of bytes that were not rewritten, and the handling of a write on the same cycle as a start can be shown only by the bench. The bench does this by following data through whole multiframes and comparing with a model of the stores.

// File: rtl/sbstk_pkg.sv
package sbstk_pkg;
  localparam int SB_BYTES   = 5;
  localparam int SB_BYTE_W  = 8;
  localparam int SB_FRAME_W = 4;

  // Pick the bit of a stored byte that belongs to a given frame.
  // Service words sit in odd frames; frame 1 takes the MSB.
  function automatic logic sb_pick_bit(input logic [SB_BYTE_W-1:0] byte_v,
                                       input logic [SB_FRAME_W-1:0] fr);
    logic [SB_FRAME_W-2:0] slot;
    slot = fr[SB_FRAME_W-1:1];
    return byte_v[SB_BYTE_W-1-int'(slot)];
  endfunction
endpackage

// File: rtl/sbstk_collect.sv
module sbstk_collect #(
  parameter int NBYTES = sbstk_pkg::SB_BYTES,
  parameter int BYTE_W = sbstk_pkg::SB_BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mf_start,
  input  logic                     wr_en,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [NBYTES*BYTE_W-1:0] stage_flat,
  output logic                     last_wr
);
  localparam int PTR_W = $clog2(NBYTES + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(NBYTES);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

  logic [PTR_W-1:0] wr_ptr;
  logic             accept;

  // A write with the pointer below the limit is taken; on a start it lands in byte 0.
  assign accept  = wr_en && (mf_start || (wr_ptr < PTR_FULL));
  assign last_wr = wr_en && !mf_start && (wr_ptr == PTR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      wr_ptr <= '0;
    else if (mf_start)
      wr_ptr <= wr_en ? PTR_W'(1) : '0;
    else if (accept)
      wr_ptr <= wr_ptr + PTR_W'(1);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_stage
    logic hit;
    assign hit = accept && (mf_start ? (b == 0) : (wr_ptr == PTR_W'(b)));
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage_flat[b*BYTE_W +: BYTE_W] <= '1;
      else if (hit)
        stage_flat[b*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_FULL);

  assert_full_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == PTR_FULL && !mf_start) |=> $stable(stage_flat));
endmodule

// File: rtl/sbstk_shadow_mux.sv
module sbstk_shadow_mux #(
  parameter int NBYTES  = sbstk_pkg::SB_BYTES,
  parameter int BYTE_W  = sbstk_pkg::SB_BYTE_W,
  parameter int FRAME_W = sbstk_pkg::SB_FRAME_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mf_start,
  input  logic [NBYTES*BYTE_W-1:0] stage_flat,
  input  logic [FRAME_W-1:0]       frame_idx,
  input  logic                     insert_en,
  output logic [NBYTES-1:0]        sa_bits,
  output logic                     sa_valid
);
  logic [NBYTES*BYTE_W-1:0] shadow_flat;

  always_ff @(posedge clk) begin
    if (!rst_n)
      shadow_flat <= '1;
    else if (mf_start)
      shadow_flat <= stage_flat;
  end

  assign sa_valid = insert_en && frame_idx[0];

  // Byte 0 feeds the highest output bit (service-word position 8).
  for (genvar b = 0; b < NBYTES; b++) begin : g_mux
    assign sa_bits[NBYTES-1-b] = sa_valid
      ? sbstk_pkg::sb_pick_bit(shadow_flat[b*BYTE_W +: BYTE_W], frame_idx)
      : 1'b1;
  end

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_start |=> $stable(shadow_flat));
endmodule

// File: rtl/sbstk_request.sv
module sbstk_request (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_start,
  input  logic active,
  input  logic last_wr,
  input  logic irq_en,
  input  logic mf_irq_mask,
  output logic sa_request,
  output logic mf_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa_request <= 1'b0;
      mf_irq     <= 1'b0;
    end else begin
      mf_irq <= mf_start && active && irq_en && mf_irq_mask;
      if (!active)
        sa_request <= 1'b0;
      else if (mf_start)
        sa_request <= 1'b1;
      else if (last_wr)
        sa_request <= 1'b0;
    end
  end

  assert_req_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && !mf_start) |=> !sa_request);

  assert_req_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sa_request);

  assert_irq_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mf_irq |-> $past(mf_start));
endmodule

// File: rtl/spare_bit_tx_stack.sv
module spare_bit_tx_stack #(
  parameter int NBYTES  = sbstk_pkg::SB_BYTES,
  parameter int BYTE_W  = sbstk_pkg::SB_BYTE_W,
  parameter int FRAME_W = sbstk_pkg::SB_FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               frame_start,
  input  logic               crc_mode_en,
  input  logic               spare_en,
  input  logic               ts0_transparent,
  input  logic               irq_en,
  input  logic               mf_irq_mask,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [NBYTES-1:0]  sa_bits,
  output logic               sa_valid,
  output logic               sa_request,
  output logic               mf_irq
);
  logic                     mf_start;
  logic                     stack_active;
  logic                     insert_en;
  logic                     last_wr;
  logic [NBYTES*BYTE_W-1:0] stage_flat;

  assign mf_start     = frame_start && (frame_idx == '0);
  assign stack_active = crc_mode_en && spare_en;
  assign insert_en    = stack_active && !ts0_transparent;

  sbstk_collect #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .wr_en(wr_en),
    .wr_data(wr_data), .stage_flat(stage_flat), .last_wr(last_wr));

  sbstk_shadow_mux #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .FRAME_W(FRAME_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .stage_flat(stage_flat),
    .frame_idx(frame_idx), .insert_en(insert_en), .sa_bits(sa_bits),
    .sa_valid(sa_valid));

  sbstk_request u_req (
    .clk(clk), .rst_n(rst_n), .mf_start(mf_start), .active(stack_active),
    .last_wr(last_wr), .irq_en(irq_en), .mf_irq_mask(mf_irq_mask),
    .sa_request(sa_request), .mf_irq(mf_irq));

  assert_transp_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ts0_transparent |-> (!sa_valid && sa_bits == '1));
endmodule

// File: tb/spare_bit_tx_stack_test.sv
module spare_bit_tx_stack_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] frame_idx = 4'd1;
  logic       frame_start = 1'b0;
  logic       crc_mode_en = 1'b1, spare_en = 1'b1, ts0_transparent = 1'b0;
  logic       irq_en = 1'b1, mf_irq_mask = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] sa_bits;
  logic       sa_valid, sa_request, mf_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_stage [5];
  logic [7:0] m_shadow [5];
  int         m_ptr;
  logic       m_req, m_irq;
  int         fr = 0, sub = 0;

  spare_bit_tx_stack uut (.*);

  always #2 clk = ~clk;

  function automatic logic [4:0] exp_bits(input int f, input logic ins);
    logic [4:0] r;
    r = 5'h1F;
    if (ins && (f % 2 == 1))
      for (int b = 0; b < 5; b++) r[4-b] = m_shadow[b][7 - f/2];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    logic act_on, ins;
    string t;
    act_on = crc_mode_en && spare_en;
    ins    = act_on && !ts0_transparent;
    t = !act_on ? "R2" : (ts0_transparent ? "R3" : tag);
    chk(t, {27'd0, sa_bits}, {27'd0, exp_bits(int'(frame_idx), ins)});
    chk(t, {31'd0, sa_valid}, {31'd0, ins && frame_idx[0]});
    chk("R7", {31'd0, sa_request}, {31'd0, m_req});
    chk("R10", {31'd0, mf_irq}, {31'd0, m_irq});
  endtask

  // One clock: drive now (at negedge), update model at the edge, check at next negedge.
  task automatic step(input logic we, input logic [7:0] d, input string tag);
    logic mfs, act_on;
    frame_idx   = 4'(fr);
    frame_start = (sub == 0);
    wr_en       = we;
    wr_data     = d;
    @(posedge clk);
    mfs    = frame_start && (frame_idx == 0);
    act_on = crc_mode_en && spare_en;
    m_irq  = mfs && act_on && irq_en && mf_irq_mask;
    if (!act_on) m_req = 0;
    else if (mfs) m_req = 1;
    else if (we && m_ptr == 4) m_req = 0;
    if (mfs) begin
      for (int b = 0; b < 5; b++) m_shadow[b] = m_stage[b];
      if (we) begin m_stage[0] = d; m_ptr = 1; end
      else m_ptr = 0;
    end else if (we && m_ptr < 5) begin
      m_stage[m_ptr] = d;
      m_ptr++;
    end
    @(negedge clk);
    check_outputs(tag);
    sub++;
    if (sub == 3) begin sub = 0; fr = (fr + 1) % 16; end
  endtask

  task automatic idle_to_mf_start(input string tag);
    while (!(fr == 0 && sub == 0)) step(1'b0, 8'h00, tag);
  endtask

  task automatic idle_mf(input int n, input string tag);
    for (int i = 0; i < n * 48; i++) step(1'b0, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < 5; b++) begin m_stage[b] = 8'hFF; m_shadow[b] = 8'hFF; end
    m_ptr = 0; m_req = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    // R1: reset state on the outputs
    chk("R1", {27'd0, sa_bits}, 32'h1F);
    chk("R1", {31'd0, sa_valid}, 32'd1);
    chk("R1", {31'd0, sa_request}, 32'd0);
    chk("R1", {31'd0, mf_irq}, 32'd0);
    rst_n = 1'b1;
    step(1'b0, 8'h00, "R1");

    // R4: directed pattern, five distinct bytes written in one multiframe
    idle_to_mf_start("R4");
    step(1'b0, 8'h00, "R4");
    step(1'b1, 8'hA5, "R5");
    step(1'b1, 8'h3C, "R5");
    step(1'b1, 8'h81, "R5");
    step(1'b1, 8'h7E, "R5");
    step(1'b1, 8'h0F, "R5");
    idle_to_mf_start("R5");
    idle_mf(1, "R4");
    idle_mf(2, "R6");

    // R8: six writes in one multiframe; the sixth is dropped
    idle_to_mf_start("R6");
    step(1'b0, 8'h00, "R6");
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h10 + i * 8'h11), "R8");
    idle_to_mf_start("R8");
    idle_mf(1, "R8");

    // R9: only two bytes rewritten
    step(1'b0, 8'h00, "R9");
    step(1'b1, 8'hC3, "R9");
    step(1'b1, 8'h5A, "R9");
    idle_to_mf_start("R9");
    idle_mf(1, "R9");

    // R11: write on the multiframe-start cycle
    idle_to_mf_start("R11");
    step(1'b1, 8'h96, "R11");
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h21 * (i + 1)), "R11");
    idle_to_mf_start("R11");
    idle_mf(1, "R11");

    // R10: interrupt masked, then unmasked
    mf_irq_mask = 1'b0;
    idle_mf(1, "R10");
    mf_irq_mask = 1'b1;
    irq_en = 1'b0;
    idle_mf(1, "R10");
    irq_en = 1'b1;

    // Random traffic with occasional mode changes (R2, R3 tagged automatically)
    for (int i = 0; i < 6000; i++) begin
      if (i % 97 == 0) begin
        crc_mode_en     = ($urandom % 8) != 0;
        spare_en        = ($urandom % 8) != 0;
        ts0_transparent = ($urandom % 6) == 0;
        mf_irq_mask     = ($urandom % 4) != 0;
      end
      step(($urandom % 10) < 2, 8'($urandom), "R4");
    end

    // R2: forced disable
    crc_mode_en = 1'b0; spare_en = 1'b1; ts0_transparent = 1'b0;
    idle_mf(1, "R2");
    crc_mode_en = 1'b1; spare_en = 1'b0;
    idle_mf(1, "R2");
    // R3: forced transparent
    spare_en = 1'b1; ts0_transparent = 1'b1;
    idle_mf(1, "R3");
    ts0_transparent = 1'b0;
    idle_mf(1, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule